// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block reads 16-bit words from a small three-wire serial EEPROM. It drives chip select, shift clock and data-in, and it samples data-out. A client asks for one word by giving a word address. The controller selects the part and shifts out a start bit, the two-bit read opcode and the address, MSB first. It then clocks in sixteen data bits, MSB first, and deselects the part.

After reset, and before it takes any client request, the block runs a boot sequence on its own. It reads word 0 using an 8-bit address. If that word holds the probe value 0x8129, the part is taken to use 8-bit addresses; any other value selects 6-bit addresses. Using the detected width, it then reads words 7, 8 and 9 and packs them into a 48-bit station address. At the end it gives a single-cycle completion pulse.

Every half period of the serial clock lasts `PHASE_CYC` system cycles. The default of 100 gives 1 µs per phase at 100 MHz.

Top module: `sprom_reader`

## Requirements
- R1: A read sends 3 + W command bits MSB first: the start bit 1, the opcode bits 1 then 0, then the address. W is 8 in wide mode, where all 8 address bits are sent. W is 6 in narrow mode, where only `req_addr[5:0]` is sent.
- R2: `ee_cs` rises while `ee_sk` is low, and `ee_sk` stays low for at least one phase before its first rise. `ee_sk` is high only while `ee_cs` is high. `ee_cs` falls at the end of every access.
- R3: `ee_di` changes only while `ee_sk` is low. It holds steady for the whole of each high phase.
- R4: After the command bits come exactly sixteen rising edges of `ee_sk`. `ee_do` is sampled during each of the matching high phases. The first bit sampled becomes `rd_data[15]`, and `rd_data` holds the word addressed.
- R5: Every high phase and every low phase of `ee_sk` inside an access lasts at least `PHASE_CYC` system cycles.
- R6: After reset, word 0 is read with an 8-bit address (11 command bits). `wide_addr` becomes 1 exactly when that word equals 0x8129, and 0 otherwise.
- R7: Words 7, 8 and 9 are then read with the detected width. `station_addr[15:0]` holds word 7, `[31:16]` holds word 8 and `[47:32]` holds word 9. Address byte n sits at bits [8n+7:8n], so byte 0 is the low byte of word 7.
- R8: `busy` is high from reset until the boot sequence ends. `init_done` pulses for one cycle, and `busy` is low in that cycle.
- R9: A `req` seen while `busy` is low starts a read, and `busy` is high from the next cycle onward. `rd_valid` pulses for one cycle, in the first cycle in which `busy` is low again. Boot reads never raise `rd_valid`.
- R10: A `req` seen while `busy` is high is ignored. It starts no access and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Read request, sampled while `busy` is low |
| req_addr | input | 8 | Word address of the request |
| busy | output | 1 | Boot sequence or read in progress |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the requested word |
| rd_data | output | 16 | Last word read |
| init_done | output | 1 | One-cycle pulse at the end of the boot sequence |
| wide_addr | output | 1 | 1 = 8-bit addressing detected, 0 = 6-bit |
| station_addr | output | 48 | Station address loaded from words 7 to 9 |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |

## Verification
The boot sequence is run three times against an EEPROM model that decodes the pins. Word 0 is set in turn to the probe value, to a value one count away from it, and to the probe with its bytes swapped. The three runs tell exact-match detection apart from a partial or byte-order-blind comparison, and they confirm the station-address byte packing in both widths. Seeded random addresses spanning the full 8-bit range are read in both modes. In narrow mode they show that bits 7:6 are dropped and that the command length follows the detected width. The model also flags phase lengths, data-in movement during a high phase, select setup and bit counts. A request pulsed in the middle of an access checks that it is dropped: the bench watches `rd_valid` and the model's access log for a second transfer.

// File: rtl/sprom_pkg.sv
// Package: shared constants and state types for the serial EEPROM reader.
// Assumes a part that uses a start bit, a two-bit opcode and 6 or 8 address bits.
package sprom_pkg;
    localparam int WORD_W      = 16;
    localparam int ADDR_WIDE   = 8;
    localparam int ADDR_NARROW = 6;
    localparam int OPC_W       = 3;
    localparam int CMD_MAX     = OPC_W + ADDR_WIDE;
    localparam int BITCNT_W    = $clog2(CMD_MAX + WORD_W + 1);
    localparam logic [OPC_W-1:0] OPC_READ = 3'b110;

    typedef enum logic [2:0] {
        E_IDLE, E_SEL, E_LO, E_HI, E_TAIL, E_DESEL
    } eng_st_t;

    typedef enum logic [2:0] {
        B_START0, B_WAIT0, B_STARTS, B_WAITS, B_FIN
    } boot_st_t;
endpackage

// File: rtl/sprom_phase_timer.sv
// Module: phase timer. It counts PHASE_CYC cycles after each restart and raises
// tick in the last cycle of the phase. Assumes PHASE_CYC >= 1.
module sprom_phase_timer #(
    parameter int PHASE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(PHASE_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Reload on restart, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= CW'(PHASE_CYC - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/sprom_engine.sv
// Module: serial access engine. It runs one read access: select, command bits,
// sixteen data bits, a tail phase and a deselect phase. Pin outputs are
// registered from the next-state values. Assumes sdo has already been
// synchronized and start is raised only while active is low.
module sprom_engine
    import sprom_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  start,
    input  logic [ADDR_WIDE-1:0]  start_addr,
    input  logic                  start_wide,
    input  logic                  sdo,
    output logic                  advance,
    output logic                  active,
    output logic                  done,
    output logic [WORD_W-1:0]     rdata,
    output logic                  ee_cs,
    output logic                  ee_sk,
    output logic                  ee_di
);
    localparam int NC_W = $clog2(CMD_MAX + 1);

    eng_st_t               st_q, st_d;
    logic [CMD_MAX-1:0]    cmd_q, cmd_d;
    logic [BITCNT_W-1:0]   bit_q, bit_d, last_bit;
    logic [NC_W-1:0]       ncmd_q, ncmd_d;
    logic [WORD_W-1:0]     shin_q, shin_d, rdata_q;
    logic                  done_q, done_d;
    logic                  cs_q, sk_q, di_q, di_d;

    assign last_bit = BITCNT_W'(ncmd_q) + BITCNT_W'(WORD_W - 1);

    // Next-state, shift-register and pin-value computation.
    always_comb begin
        st_d   = st_q;
        cmd_d  = cmd_q;
        bit_d  = bit_q;
        ncmd_d = ncmd_q;
        shin_d = shin_q;
        done_d = 1'b0;
        case (st_q)
            E_IDLE: if (start) begin
                st_d  = E_SEL;
                bit_d = '0;
                if (start_wide) begin
                    ncmd_d = NC_W'(CMD_MAX);
                    cmd_d  = {OPC_READ, start_addr};
                end else begin
                    ncmd_d = NC_W'(OPC_W + ADDR_NARROW);
                    cmd_d  = {OPC_READ, start_addr[ADDR_NARROW-1:0],
                              {(ADDR_WIDE - ADDR_NARROW){1'b0}}};
                end
            end
            E_SEL:  if (tick) st_d = E_LO;
            E_LO:   if (tick) st_d = E_HI;
            E_HI:   if (tick) begin
                if (bit_q >= BITCNT_W'(ncmd_q))
                    shin_d = {shin_q[WORD_W-2:0], sdo};
                cmd_d = cmd_q << 1;
                if (bit_q == last_bit)
                    st_d = E_TAIL;
                else begin
                    st_d  = E_LO;
                    bit_d = bit_q + 1'b1;
                end
            end
            E_TAIL:  if (tick) st_d = E_DESEL;
            E_DESEL: if (tick) begin
                st_d   = E_IDLE;
                done_d = 1'b1;
            end
            default: st_d = E_IDLE;
        endcase
        di_d = ((st_d == E_LO) || (st_d == E_HI)) &&
               (bit_d < BITCNT_W'(ncmd_d)) && cmd_d[CMD_MAX-1];
    end

    // State, shifter and registered pin outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= E_IDLE;
            cmd_q   <= '0;
            bit_q   <= '0;
            ncmd_q  <= '0;
            shin_q  <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            cs_q    <= 1'b0;
            sk_q    <= 1'b0;
            di_q    <= 1'b0;
        end else begin
            st_q   <= st_d;
            cmd_q  <= cmd_d;
            bit_q  <= bit_d;
            ncmd_q <= ncmd_d;
            shin_q <= shin_d;
            done_q <= done_d;
            if (done_d)
                rdata_q <= shin_q;
            cs_q <= (st_d == E_SEL) || (st_d == E_LO) ||
                    (st_d == E_HI)  || (st_d == E_TAIL);
            sk_q <= (st_d == E_HI);
            di_q <= di_d;
        end
    end

    assign advance = (st_q == E_IDLE) ? start : tick;
    assign active  = (st_q != E_IDLE);
    assign done    = done_q;
    assign rdata   = rdata_q;
    assign ee_cs   = cs_q;
    assign ee_sk   = sk_q;
    assign ee_di   = di_q;
endmodule

// File: rtl/sprom_boot.sv
// Module: boot sequencer. After reset it reads word 0 in wide mode, chooses
// the address width from the probe value, then loads words 7 to 9 into the
// station address. Assumes each start is issued only while the engine is idle.
module sprom_boot
    import sprom_pkg::*;
#(
    parameter logic [WORD_W-1:0] PROBE_WORD = 16'h8129
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   eng_done,
    input  logic [WORD_W-1:0]      eng_data,
    output logic                   go,
    output logic [ADDR_WIDE-1:0]   go_addr,
    output logic                   go_wide,
    output logic                   boot_done,
    output logic                   init_done,
    output logic                   wide_addr,
    output logic [3*WORD_W-1:0]    station_addr
);
    localparam int NWORDS = 3;
    localparam int BASE   = 7;
    localparam int IW     = $clog2(NWORDS);

    boot_st_t              st_q;
    logic [IW-1:0]         idx_q;
    logic                  wide_q, pulse_q;
    logic [3*WORD_W-1:0]   sta_q;

    // Sequence through the probe read and the station-word reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= B_START0;
            idx_q   <= '0;
            wide_q  <= 1'b0;
            pulse_q <= 1'b0;
            sta_q   <= '0;
        end else begin
            pulse_q <= 1'b0;
            case (st_q)
                B_START0: st_q <= B_WAIT0;
                B_WAIT0: if (eng_done) begin
                    wide_q <= (eng_data == PROBE_WORD);
                    st_q   <= B_STARTS;
                end
                B_STARTS: st_q <= B_WAITS;
                B_WAITS: if (eng_done) begin
                    sta_q[WORD_W*idx_q +: WORD_W] <= eng_data;
                    if (idx_q == IW'(NWORDS - 1)) begin
                        st_q    <= B_FIN;
                        pulse_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= B_STARTS;
                    end
                end
                default: st_q <= B_FIN;
            endcase
        end
    end

    assign go           = (st_q == B_START0) || (st_q == B_STARTS);
    assign go_addr      = (st_q == B_START0) ? '0 : ADDR_WIDE'(BASE) + ADDR_WIDE'(idx_q);
    assign go_wide      = (st_q == B_START0) ? 1'b1 : wide_q;
    assign boot_done    = (st_q == B_FIN);
    assign init_done    = pulse_q;
    assign wide_addr    = wide_q;
    assign station_addr = sta_q;
endmodule

// File: rtl/sprom_reader.sv
// Module: top of the serial EEPROM word reader. It synchronizes data-out,
// shares one engine between the boot sequencer and client requests, and
// drops requests that arrive while busy. Assumes PHASE_CYC >= 3, so that a
// synchronized sample is taken after data-out has settled in the high phase.
module sprom_reader #(
    parameter int          PHASE_CYC  = 100,
    parameter logic [15:0] PROBE_WORD = 16'h8129
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [7:0]  req_addr,
    output logic        busy,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        init_done,
    output logic        wide_addr,
    output logic [47:0] station_addr,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do
);
    import sprom_pkg::*;

    logic                 sync1_q, sync2_q;
    logic                 tick, advance, eng_active, eng_done;
    logic                 eng_start, eng_wide;
    logic [ADDR_WIDE-1:0] eng_addr;
    logic [WORD_W-1:0]    eng_data;
    logic                 boot_go, boot_wide, boot_done;
    logic [ADDR_WIDE-1:0] boot_addr;
    logic                 user_go;

    // Two-flop synchronizer on serial data-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ee_do;
            sync2_q <= sync1_q;
        end
    end

    assign user_go   = boot_done && !eng_active && req;
    assign eng_start = boot_go || user_go;
    assign eng_addr  = boot_go ? boot_addr : req_addr;
    assign eng_wide  = boot_go ? boot_wide : wide_addr;

    sprom_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (advance),
        .tick    (tick)
    );

    sprom_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (eng_start),
        .start_addr (eng_addr),
        .start_wide (eng_wide),
        .sdo        (sync2_q),
        .advance    (advance),
        .active     (eng_active),
        .done       (eng_done),
        .rdata      (eng_data),
        .ee_cs      (ee_cs),
        .ee_sk      (ee_sk),
        .ee_di      (ee_di)
    );

    sprom_boot #(.PROBE_WORD(PROBE_WORD)) u_boot (
        .clk          (clk),
        .rst_n        (rst_n),
        .eng_done     (eng_done),
        .eng_data     (eng_data),
        .go           (boot_go),
        .go_addr      (boot_addr),
        .go_wide      (boot_wide),
        .boot_done    (boot_done),
        .init_done    (init_done),
        .wide_addr    (wide_addr),
        .station_addr (station_addr)
    );

    assign busy     = !boot_done || eng_active;
    assign rd_valid = eng_done && boot_done;
    assign rd_data  = eng_data;
endmodule

// File: rtl/sprom_reader_chk.sv
// Module: protocol checker for sprom_reader, attached by bind. It watches the
// serial pins and the handshake outputs; a saturating counter measures the
// length of each clock level.
module sprom_reader_chk #(
    parameter int PHASE_CYC = 100
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic rd_valid,
    input logic init_done,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_di
);
    localparam int RW = $clog2(PHASE_CYC + 2);

    logic          sk_prev;
    logic [RW-1:0] run_q;

    // Measure how many cycles the shift clock has held its current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_prev <= 1'b0;
            run_q   <= '0;
        end else begin
            sk_prev <= ee_sk;
            if (ee_sk != sk_prev)
                run_q <= RW'(1);
            else if (int'(run_q) < PHASE_CYC + 1)
                run_q <= run_q + 1'b1;
        end
    end

    a_r2_select_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_sk);
    a_r2_clk_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);
    a_r3_di_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
    a_r5_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cs && (ee_sk != sk_prev)) |-> (int'(run_q) >= PHASE_CYC));
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!busy && $past(busy)));
    a_r9_valid_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!busy && $past(busy)));
endmodule

bind sprom_reader sprom_reader_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .init_done (init_done),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di)
);

// File: tb/sprom_reader_tb.sv
// Bench: a pin-level EEPROM model, directed boot cases and seeded random reads.
module sprom_reader_tb;
    localparam int PH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        busy, rd_valid, init_done, wide_addr;
    logic [15:0] rd_data;
    logic [47:0] station_addr;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [15:0] w0 = 16'h8129;
    logic        exp_wide = 1'b1;

    always #5 clk = ~clk;

    sprom_reader #(.PHASE_CYC(PH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .init_done(init_done), .wide_addr(wide_addr),
        .station_addr(station_addr), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do)
    );

    function automatic logic [15:0] mem_word(input int a);
        if (a == 0) return w0;
        return 16'((a * 40503 + 4660) ^ (a << 7));
    endfunction

    task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // EEPROM model: decodes the pins at negedge and logs protocol violations.
    logic p_cs = 0, p_sk = 0, p_di = 0;
    int run_sk = 0, sel_run = 0, edge_n = 0, acc_idx = 0, alen = 8;
    int cmd_bad = 0, di_viol = 0, ph_viol = 0, sel_viol = 0, rv_cnt = 0;
    logic [10:0] rcv = '0;
    logic [7:0]  m_addr = '0, last_addr = '0;
    logic [15:0] m_word = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            acc_idx = 0; edge_n = 0; ee_do = 1'b0;
            p_cs = 0; p_sk = 0; p_di = 0; run_sk = 0;
        end else begin
            alen = (acc_idx == 0 || exp_wide) ? 8 : 6;
            if (rd_valid) rv_cnt++;
            if (ee_sk != p_sk) begin
                if (ee_cs && run_sk < PH) ph_viol++;
                run_sk = 1;
            end else run_sk++;
            if (ee_sk && p_sk && ee_di != p_di) di_viol++;
            if (ee_sk && !ee_cs) sel_viol++;
            if (ee_cs && !p_cs) begin
                sel_run = 0; edge_n = 0; rcv = '0;
                if (ee_sk) sel_viol++;
            end
            if (ee_cs && edge_n == 0 && !ee_sk) sel_run++;
            if (ee_cs && ee_sk && !p_sk) begin
                if (edge_n == 0 && sel_run < PH) sel_viol++;
                edge_n++;
                if (edge_n <= alen + 3) begin
                    rcv = {rcv[9:0], ee_di};
                    if (edge_n == alen + 3) begin
                        if (alen == 8) begin
                            if (rcv[10:8] != 3'b110) cmd_bad++;
                            m_addr = rcv[7:0];
                        end else begin
                            if (rcv[8:6] != 3'b110) cmd_bad++;
                            m_addr = {2'b00, rcv[5:0]};
                        end
                        m_word = mem_word(int'(m_addr));
                    end
                end else if (edge_n <= alen + 19) begin
                    ee_do = m_word[15 - (edge_n - alen - 4)];
                end
            end
            if (!ee_cs && p_cs) begin
                if (edge_n != alen + 19) cmd_bad++;
                acc_idx++;
                last_addr = m_addr;
                ee_do = 1'b0;
            end
            p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
        end
    end

    task automatic boot(input logic [15:0] word0, input logic wide);
        @(negedge clk);
        rst_n = 1'b0;
        w0 = word0;
        exp_wide = wide;
        repeat (3) @(negedge clk);
        check("R8 reset busy", 64'(busy), 64'd1);
        check("R2 reset pins", {62'd0, ee_cs, ee_sk}, 64'd0);
        check("R9 reset rd_valid", {62'd0, rd_valid, init_done}, 64'd0);
        rst_n = 1'b1;
        while (!init_done) @(negedge clk);
        check("R8 busy at init_done", 64'(busy), 64'd0);
        check("R6 width detect", 64'(wide_addr), 64'(wide));
        check("R7 station address", 64'(station_addr),
              64'({mem_word(9), mem_word(8), mem_word(7)}));
        check("R1 boot command bits", 64'(cmd_bad), 64'd0);
        check("R9 no valid during boot", 64'(rv_cnt), 64'd0);
        @(negedge clk);
        check("R8 init_done one cycle", 64'(init_done), 64'd0);
    endtask

    task automatic user_read(input logic [7:0] a);
        logic [7:0] ea;
        ea = wide_addr ? a : {2'b00, a[5:0]};
        while (busy) @(negedge clk);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        req = 1'b0;
        check("R9 busy after req", 64'(busy), 64'd1);
        while (!rd_valid) @(negedge clk);
        check("R9 busy low at valid", 64'(busy), 64'd0);
        check("R4 read data", 64'(rd_data), 64'(mem_word(int'(ea))));
        @(negedge clk);
        check("R1 address sent", 64'(last_addr), 64'(ea));
        check("R9 valid one cycle", 64'(rd_valid), 64'd0);
    endtask

    task automatic pin_rules();
        check("R1 command framing", 64'(cmd_bad), 64'd0);
        check("R2 select setup", 64'(sel_viol), 64'd0);
        check("R3 di held in high phase", 64'(di_viol), 64'd0);
        check("R5 phase length", 64'(ph_viol), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int unsigned r;
        int base;
        r = $urandom(32'd20240);
        // Wide part: exact probe value.
        boot(16'h8129, 1'b1);
        user_read(8'hFF);
        user_read(8'h00);
        user_read(8'hC5);
        for (int i = 0; i < 15; i++) user_read(8'($urandom()));
        pin_rules();
        // R10: a request while busy is dropped.
        base = rv_cnt;
        while (busy) @(negedge clk);
        req = 1'b1; req_addr = 8'h3A;
        @(negedge clk);
        req = 1'b0;
        repeat (20) @(negedge clk);
        req = 1'b1; req_addr = 8'hB7;
        @(negedge clk);
        req = 1'b0;
        while (!rd_valid) @(negedge clk);
        check("R10 data of first request", 64'(rd_data), 64'(mem_word(8'h3A)));
        repeat (400) @(negedge clk);
        check("R10 single valid", 64'(rv_cnt - base), 64'd1);
        check("R10 no hidden access", {63'd0, busy}, 64'd0);
        check("R10 last address", 64'(last_addr), 64'h3A);
        // Narrow part: value one count off the probe.
        rv_cnt = 0;
        boot(16'h8128, 1'b0);
        user_read(8'hFF);
        user_read(8'h40);
        for (int i = 0; i < 15; i++) user_read(8'($urandom()));
        pin_rules();
        // Narrow part: probe with bytes swapped.
        rv_cnt = 0;
        boot(16'h2981, 1'b0);
        user_read(8'h87);
        pin_rules();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule